// File: doc/BRIEF.md
# Dual Time Alarm with Interrupt / Square-Wave Pin Control

This block sits beside a BCD timekeeper and watches its live fields. It holds two alarm settings. The first alarm can compare seconds, minutes, hours and day-or-date. The second alarm compares minutes, hours and day-or-date, and fires only on the zero-second boundary. Each alarm byte carries its own ignore bit. Clearing or setting these ignore bits chooses how often the alarm repeats. The alarms are evaluated only on the cycle where the one-second strobe is high. A hit latches a sticky flag, and software can clear that flag but never set it.

One shared open-drain pin is driven from a single registered enable, `pin_pull_n`, which is low when the pin must be pulled down. A mode bit chooses what drives the pin:
- In interrupt mode the pin is pulled low while any enabled flag is set.
- In wave mode the pin follows a square wave. The wave toggles on one of four external rate strobes, chosen by two rate bits.

While the chip runs from its backup supply, the pin is released unless a dedicated enable bit allows it to stay active.

Register map, byte-wide, by address:
- 0: alarm-1 seconds
- 1: alarm-1 minutes
- 2: alarm-1 hours
- 3: alarm-1 day/date
- 4: alarm-2 minutes
- 5: alarm-2 hours
- 6: alarm-2 day/date
- 7: control
- 8: flags

Addresses 9 and up read as zero.

Top module: `rtc_alarm_irq`

## Requirements
- R1: After reset, control reads 0x18 (wave mode, rate code 11, both enables and backup enable 0), flags read 0x00, and `pin_pull_n` is 1.
- R2: A write to address 0..7 is visible on `rd_data` one cycle after `rd_addr` selects it. Control bits 7:6 always read 0. The control layout is: bit 0 alarm-1 enable, bit 1 alarm-2 enable, bit 2 interrupt mode, bits 4:3 rate code, bit 5 backup enable.
- R3: Alarm-1 ignore bits (bit 7 of bytes 0..3) select the repeat rate. With all four set it fires every tick. With only seconds compared it fires when seconds match. Each further cleared bit (minutes, hours, then day/date) adds that field to the comparison. A hit sets flag bit 0.
- R4: Alarm-2 fires only on a tick whose seconds field is 0x00. With all three ignore bits set it fires once per minute. Clearing the ignore bits adds minutes, then hours, then day/date to the comparison. A hit sets flag bit 1.
- R5: In a day/date alarm byte, bit 6 = 1 compares bits 5:0 against the weekday input, and bit 6 = 0 compares them against the day-of-month input.
- R6: The hour comparison covers bits 6:0 of the hours byte, including the 12-hour select and PM bits.
- R7: Flags change only on a cycle with `tick_1hz` high. A matching time without a tick sets nothing.
- R8: Writing 0 to a flag bit clears it. Writing 1 leaves it unchanged.
- R9: A hit and a clearing write in the same cycle leave the flag set.
- R10: In wave mode the wave toggles only on the rate strobe chosen by the rate code: 00 selects tap 0 (1 Hz), 01 tap 1, 10 tap 2, 11 tap 3 (fastest). `pin_pull_n` follows the wave, which starts at 1.
- R11: In interrupt mode `pin_pull_n` is 0 while (flag0 AND enable1) OR (flag1 AND enable2), and stays 0 until that term drops.
- R12: With `on_backup` high and backup enable 0, `pin_pull_n` is 1. With backup enable 1, the pin behaves as in R10/R11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1hz | input | 1 | One-cycle strobe, alarms evaluated on it |
| tm_sec | input | 8 | Live BCD seconds |
| tm_min | input | 8 | Live BCD minutes |
| tm_hour | input | 8 | Live hours byte with mode and PM bits |
| tm_wday | input | 8 | Live weekday |
| tm_mday | input | 8 | Live BCD day of month |
| sq_taps | input | 4 | Rate strobes, one per square-wave rate |
| on_backup | input | 1 | High while running from backup supply |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 4 | Read address |
| rd_data | output | 8 | Registered read data |
| pin_pull_n | output | 1 | 0 = pull shared pin low, 1 = release |

## Verification
Register results appear one cycle after the address or write that causes them. A flag is readable one cycle after the tick that sets it. The pin follows a flag, control or tap change two cycles after the stimulus, because it passes through the flag or wave register and then the output register. Each scoreboard entry carries the exact cycle on which its result becomes due. The monitor compares on the falling edge of that cycle. Stimulus tasks also leave a settling gap before steady-state pin checks, so no comparison lands on a transition.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;
  localparam int BYTE_W   = 8;
  localparam int A1_BYTES = 4;
  localparam int A2_BYTES = 3;
  localparam int ALM_CNT  = A1_BYTES + A2_BYTES;

  localparam int ADR_A1_SEC  = 0;
  localparam int ADR_A2_MIN  = A1_BYTES;
  localparam int ADR_CTRL    = ALM_CNT;
  localparam int ADR_FLAGS   = ALM_CNT + 1;

  typedef struct packed {
    logic [1:0] rsv;
    logic       bkup_en;
    logic [1:0] rate;
    logic       irq_mode;
    logic       a2_en;
    logic       a1_en;
  } ctrl_t;

  localparam logic [BYTE_W-1:0] CTRL_RST = 8'h18;
endpackage

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match #(
  parameter bit HAS_SEC = 1'b1
) (
  input  logic       tick,
  input  logic [7:0] a_sec,
  input  logic [7:0] a_min,
  input  logic [7:0] a_hour,
  input  logic [7:0] a_dd,
  input  logic [7:0] t_sec,
  input  logic [7:0] t_min,
  input  logic [7:0] t_hour,
  input  logic [7:0] t_wday,
  input  logic [7:0] t_mday,
  output logic       fire
);
  logic sec_ok, min_ok, hour_ok, dd_ok;
  logic [7:0] dd_ref;

  // ignore bit in bit 7 of every alarm byte; masked field always agrees
  always_comb begin
    if (HAS_SEC) sec_ok = a_sec[7] | ({1'b0, a_sec[6:0]} == t_sec);
    else         sec_ok = a_sec[7] & (t_sec == 8'h00);
    min_ok  = a_min[7]  | ({1'b0, a_min[6:0]}  == t_min);
    hour_ok = a_hour[7] | ({1'b0, a_hour[6:0]} == t_hour);
    dd_ref  = a_dd[6] ? t_wday : t_mday;
    dd_ok   = a_dd[7] | ({2'b00, a_dd[5:0]} == dd_ref);
    fire    = tick & sec_ok & min_ok & hour_ok & dd_ok;
  end
endmodule

// File: rtl/rtc_sqw_gen.sv
module rtc_sqw_gen #(
  parameter int N_RATES = 4,
  parameter int RSW     = $clog2(N_RATES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_RATES-1:0] taps,
  input  logic [RSW-1:0]     rate,
  output logic               wave
);
  always_ff @(posedge clk) begin
    if (rst)             wave <= 1'b1;
    else if (taps[rate]) wave <= ~wave;
  end

  AST_SQW_HOLD: assert property (@(posedge clk) disable iff (rst)
    !taps[rate] |=> $stable(wave)); // R10
endmodule

// File: rtl/rtc_pin_stage.sv
module rtc_pin_stage (
  input  logic clk,
  input  logic rst,
  input  logic irq_mode,
  input  logic irq_req,
  input  logic wave,
  input  logic on_backup,
  input  logic bkup_en,
  output logic pin_pull_n
);
  logic blocked;
  assign blocked = on_backup & ~bkup_en;

  always_ff @(posedge clk) begin
    if (rst)          pin_pull_n <= 1'b1;
    else if (blocked) pin_pull_n <= 1'b1;
    else if (irq_mode) pin_pull_n <= ~irq_req;
    else              pin_pull_n <= wave;
  end

  AST_BACKUP_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (on_backup && !bkup_en) |=> pin_pull_n); // R12
  AST_IRQ_PULLS: assert property (@(posedge clk) disable iff (rst)
    (irq_mode && irq_req && !on_backup) |=> !pin_pull_n); // R11
endmodule

// File: rtl/rtc_alarm_irq.sv
module rtc_alarm_irq
  import rtc_alarm_pkg::*;
#(
  parameter int AW      = 4,
  parameter int N_RATES = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick_1hz,
  input  logic [7:0]         tm_sec,
  input  logic [7:0]         tm_min,
  input  logic [7:0]         tm_hour,
  input  logic [7:0]         tm_wday,
  input  logic [7:0]         tm_mday,
  input  logic [N_RATES-1:0] sq_taps,
  input  logic               on_backup,
  input  logic               wr_en,
  input  logic [AW-1:0]      wr_addr,
  input  logic [7:0]         wr_data,
  input  logic [AW-1:0]      rd_addr,
  output logic [7:0]         rd_data,
  output logic               pin_pull_n
);
  localparam int RSW    = $clog2(N_RATES);
  localparam int ALM_IW = $clog2(ALM_CNT);

  logic [7:0] alm_q [ALM_CNT];
  ctrl_t      ctrl_q;
  logic [1:0] flag_q;
  logic [1:0] fire;
  logic [1:0] clr;
  logic       wr_alm, wr_ctrl, wr_flags;
  logic       irq_req;
  logic       wave;
  logic [7:0] rd_mux;

  assign wr_alm   = wr_en && (int'(wr_addr) < ALM_CNT);
  assign wr_ctrl  = wr_en && (wr_addr == AW'(ADR_CTRL));
  assign wr_flags = wr_en && (wr_addr == AW'(ADR_FLAGS));

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ALM_CNT; i++) alm_q[i] <= '0;
    end else if (wr_alm) begin
      alm_q[wr_addr[ALM_IW-1:0]] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          ctrl_q <= ctrl_t'(CTRL_RST);
    else if (wr_ctrl) ctrl_q <= ctrl_t'({2'b00, wr_data[5:0]});
  end

  rtc_alarm_match #(.HAS_SEC(1'b1)) u_match1 (
    .tick(tick_1hz), .a_sec(alm_q[ADR_A1_SEC]), .a_min(alm_q[ADR_A1_SEC+1]),
    .a_hour(alm_q[ADR_A1_SEC+2]), .a_dd(alm_q[ADR_A1_SEC+3]),
    .t_sec(tm_sec), .t_min(tm_min), .t_hour(tm_hour),
    .t_wday(tm_wday), .t_mday(tm_mday), .fire(fire[0])
  );

  rtc_alarm_match #(.HAS_SEC(1'b0)) u_match2 (
    .tick(tick_1hz), .a_sec(8'h80), .a_min(alm_q[ADR_A2_MIN]),
    .a_hour(alm_q[ADR_A2_MIN+1]), .a_dd(alm_q[ADR_A2_MIN+2]),
    .t_sec(tm_sec), .t_min(tm_min), .t_hour(tm_hour),
    .t_wday(tm_wday), .t_mday(tm_mday), .fire(fire[1])
  );

  // sticky flags: a new hit outranks a clearing write
  genvar g;
  generate
    for (g = 0; g < 2; g++) begin : g_flag
      assign clr[g] = wr_flags && !wr_data[g];
      always_ff @(posedge clk) begin
        if (rst)          flag_q[g] <= 1'b0;
        else if (fire[g]) flag_q[g] <= 1'b1;
        else if (clr[g])  flag_q[g] <= 1'b0;
      end

      AST_FLAG_NEEDS_TICK: assert property (@(posedge clk) disable iff (rst)
        $rose(flag_q[g]) |-> $past(tick_1hz)); // R7
      AST_FLAG_HELD: assert property (@(posedge clk) disable iff (rst)
        (flag_q[g] && !clr[g]) |=> flag_q[g]); // R8
      AST_HIT_WINS: assert property (@(posedge clk) disable iff (rst)
        fire[g] |=> flag_q[g]); // R9
    end
  endgenerate

  assign irq_req = (flag_q[0] & ctrl_q.a1_en) | (flag_q[1] & ctrl_q.a2_en);

  rtc_sqw_gen #(.N_RATES(N_RATES), .RSW(RSW)) u_sqw (
    .clk(clk), .rst(rst), .taps(sq_taps), .rate(ctrl_q.rate[RSW-1:0]), .wave(wave)
  );

  rtc_pin_stage u_pin (
    .clk(clk), .rst(rst), .irq_mode(ctrl_q.irq_mode), .irq_req(irq_req),
    .wave(wave), .on_backup(on_backup), .bkup_en(ctrl_q.bkup_en),
    .pin_pull_n(pin_pull_n)
  );

  always_comb begin
    rd_mux = '0;
    if (int'(rd_addr) < ALM_CNT)          rd_mux = alm_q[rd_addr[ALM_IW-1:0]];
    else if (rd_addr == AW'(ADR_CTRL))    rd_mux = ctrl_q;
    else if (rd_addr == AW'(ADR_FLAGS))   rd_mux = {6'b0, flag_q};
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_mux;
  end

  AST_CTRL_RSV_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_addr == AW'(ADR_CTRL)) |=> (rd_data[7:6] == 2'b00)); // R2
endmodule

// File: tb/rtc_alarm_irq_tb_top.sv
`timescale 1ns/1ps
module rtc_alarm_irq_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_1hz = 1'b0;
  logic [7:0] tm_sec = '0, tm_min = '0, tm_hour = '0, tm_wday = '0, tm_mday = '0;
  logic [3:0] sq_taps = '0;
  logic       on_backup = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [3:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       pin_pull_n;

  int cyc = 0;
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  int    q_due[$];
  bit    q_kind[$];
  logic [7:0] q_exp[$];
  string q_tag[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  rtc_alarm_irq dut_i (
    .clk(clk), .rst(rst), .tick_1hz(tick_1hz), .tm_sec(tm_sec), .tm_min(tm_min),
    .tm_hour(tm_hour), .tm_wday(tm_wday), .tm_mday(tm_mday), .sq_taps(sq_taps),
    .on_backup(on_backup), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .pin_pull_n(pin_pull_n)
  );

  // monitor: pops entries whose cycle has come
  always @(negedge clk) begin
    while (q_due.size() > 0 && q_due[0] <= cyc) begin
      logic [7:0] act, exp;
      string tag;
      bit kind;
      void'(q_due.pop_front());
      kind = q_kind.pop_front();
      exp  = q_exp.pop_front();
      tag  = q_tag.pop_front();
      act  = kind ? rd_data : {7'b0, pin_pull_n};
      n_cmp++;
      if (act !== exp) begin
        n_bad++;
        $display("FAIL %s: actual 0x%02h expected 0x%02h (cycle %0d)", tag, act, exp, cyc);
      end
    end
  end

  task automatic step(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    step();
    wr_en = 0;
  endtask

  task automatic rd_exp(input logic [3:0] a, input logic [7:0] e, input string tag);
    rd_addr = a;
    q_due.push_back(cyc + 1); q_kind.push_back(1'b1); q_exp.push_back(e); q_tag.push_back(tag);
    step();
  endtask

  task automatic pin_exp(input bit e, input string tag);
    step(2);
    q_due.push_back(cyc + 1); q_kind.push_back(1'b0); q_exp.push_back({7'b0, e}); q_tag.push_back(tag);
    step();
  endtask

  task automatic tap(input int i);
    sq_taps[i] = 1'b1;
    step();
    sq_taps = '0;
  endtask

  task automatic tick(input logic [7:0] s, m, h, wd, md);
    tm_sec = s; tm_min = m; tm_hour = h; tm_wday = wd; tm_mday = md;
    tick_1hz = 1'b1;
    step();
    tick_1hz = 1'b0;
    step();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    step(4);
    rst = 0;
    step();
    // R1 reset state
    pin_exp(1'b1, "R1 pin released");
    rd_exp(4'd7, 8'h18, "R1 control reset");
    rd_exp(4'd8, 8'h00, "R1 flags reset");

    // R10 rate code 11 uses tap 3
    tap(0); pin_exp(1'b1, "R10 unselected tap ignored");
    tap(3); pin_exp(1'b0, "R10 tap3 toggles");
    tap(3); pin_exp(1'b1, "R10 tap3 toggles back");
    wr(4'd7, 8'h00);
    tap(3); pin_exp(1'b1, "R10 rate00 ignores tap3");
    tap(0); pin_exp(1'b0, "R10 rate00 tap0");
    tap(0); pin_exp(1'b1, "R10 rate00 tap0 back");
    wr(4'd7, 8'h10);
    tap(1); pin_exp(1'b1, "R10 rate10 ignores tap1");
    tap(2); pin_exp(1'b0, "R10 rate10 tap2");
    tap(2); pin_exp(1'b1, "R10 rate10 tap2 back");

    // R2 readback
    wr(4'd5, 8'h65); rd_exp(4'd5, 8'h65, "R2 alarm byte readback");
    wr(4'd7, 8'hFF); rd_exp(4'd7, 8'h3F, "R2 control reserved bits");
    rd_exp(4'd9, 8'h00, "R2 unmapped address");
    wr(4'd5, 8'h80);

    // R3 every second, R11 irq, R8 write-zero-only
    for (int i = 0; i < 4; i++) wr(4'(i), 8'h80);
    wr(4'd7, 8'h05);
    pin_exp(1'b1, "R11 no flag no pull");
    rd_exp(4'd8, 8'h00, "R7 no tick no flag");
    tick(8'h11, 8'h22, 8'h09, 8'h02, 8'h07);
    rd_exp(4'd8, 8'h01, "R3 every-second alarm");
    pin_exp(1'b0, "R11 pin pulled by flag0");
    step(10);
    pin_exp(1'b0, "R11 pin held until clear");
    wr(4'd8, 8'h01); rd_exp(4'd8, 8'h01, "R8 write 1 keeps flag");
    wr(4'd8, 8'h00); rd_exp(4'd8, 8'h00, "R8 write 0 clears flag");
    pin_exp(1'b1, "R11 pin released after clear");
    wr(4'd8, 8'h03); rd_exp(4'd8, 8'h00, "R8 write 1 cannot set");

    // R3 seconds / minutes match
    wr(4'd0, 8'h25);
    tick(8'h24, 8'h31, 8'h09, 8'h02, 8'h07); rd_exp(4'd8, 8'h00, "R3 seconds mismatch");
    tick(8'h25, 8'h31, 8'h09, 8'h02, 8'h07); rd_exp(4'd8, 8'h01, "R3 seconds match");
    wr(4'd8, 8'h00);
    wr(4'd1, 8'h30);
    tick(8'h25, 8'h31, 8'h09, 8'h02, 8'h07); rd_exp(4'd8, 8'h00, "R3 minutes mismatch");
    tick(8'h25, 8'h30, 8'h09, 8'h02, 8'h07); rd_exp(4'd8, 8'h01, "R3 minutes match");
    wr(4'd8, 8'h00);

    // R6 hour incl. 12h/PM bits
    wr(4'd2, 8'h71);
    tick(8'h25, 8'h30, 8'h51, 8'h02, 8'h07); rd_exp(4'd8, 8'h00, "R6 AM vs PM differs");
    tick(8'h25, 8'h30, 8'h71, 8'h02, 8'h07); rd_exp(4'd8, 8'h01, "R6 full hour match");
    wr(4'd8, 8'h00);

    // R5 date vs weekday
    wr(4'd3, 8'h15);
    tick(8'h25, 8'h30, 8'h71, 8'h15, 8'h14); rd_exp(4'd8, 8'h00, "R5 date mode ignores weekday");
    tick(8'h25, 8'h30, 8'h71, 8'h03, 8'h15); rd_exp(4'd8, 8'h01, "R5 date match");
    wr(4'd8, 8'h00);
    wr(4'd3, 8'h43);
    tick(8'h25, 8'h30, 8'h71, 8'h02, 8'h03); rd_exp(4'd8, 8'h00, "R5 weekday mode ignores date");
    tick(8'h25, 8'h30, 8'h71, 8'h03, 8'h20); rd_exp(4'd8, 8'h01, "R5 weekday match");
    wr(4'd8, 8'h00);
    wr(4'd0, 8'h59);

    // R4 alarm 2
    for (int i = 4; i < 7; i++) wr(4'(i), 8'h80);
    wr(4'd7, 8'h06);
    tick(8'h01, 8'h44, 8'h09, 8'h02, 8'h07); rd_exp(4'd8, 8'h00, "R4 per-minute needs sec 00");
    tick(8'h00, 8'h44, 8'h09, 8'h02, 8'h07); rd_exp(4'd8, 8'h02, "R4 per-minute fires");
    pin_exp(1'b0, "R11 pin pulled by flag1");
    wr(4'd8, 8'h00);
    wr(4'd4, 8'h45);
    tick(8'h00, 8'h44, 8'h09, 8'h02, 8'h07); rd_exp(4'd8, 8'h00, "R4 minutes mismatch");
    tick(8'h05, 8'h45, 8'h09, 8'h02, 8'h07); rd_exp(4'd8, 8'h00, "R4 minutes match off-boundary");
    tick(8'h00, 8'h45, 8'h09, 8'h02, 8'h07); rd_exp(4'd8, 8'h02, "R4 minutes match");
    wr(4'd8, 8'h00);

    // R11 enable gating
    wr(4'd7, 8'h04);
    tick(8'h00, 8'h45, 8'h09, 8'h02, 8'h07);
    rd_exp(4'd8, 8'h02, "R11 flag set while disabled");
    pin_exp(1'b1, "R11 disabled flag no pull");
    wr(4'd7, 8'h06);
    pin_exp(1'b0, "R11 enable pulls pin");

    // R12 backup gating
    on_backup = 1'b1;
    pin_exp(1'b1, "R12 backup releases pin");
    wr(4'd7, 8'h26);
    pin_exp(1'b0, "R12 backup enable keeps irq");
    on_backup = 1'b0;

    // R9 hit and clear in same cycle
    tm_sec = 8'h00; tm_min = 8'h45;
    tick_1hz = 1'b1; wr_en = 1; wr_addr = 4'd8; wr_data = 8'h00;
    step();
    tick_1hz = 1'b0; wr_en = 0;
    rd_exp(4'd8, 8'h02, "R9 hit beats clear");
    wr(4'd8, 8'h00);
    step(5);
    rd_exp(4'd8, 8'h00, "R7 matching time without tick");
    pin_exp(1'b1, "R11 released after final clear");

    step(4);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule